// File: doc/BRIEF.md
# Display-to-Command Mode Switcher

This block sits beside a panel timing generator. It decides when the display path stops streaming pixel data and hands the panel interface over to command traffic. It watches the horizontal and vertical sync outputs of the timing generator and takes a one-cycle command strobe with an 8-bit code. From these it drives four mode signals:

- a pixel-data enable
- a force-to-black flag
- a timing-run flag
- a command-mode flag

Some codes change mode on the next clock. Others keep the picture going until a chosen sync boundary, so the panel is never left with a torn line or frame. One code also inserts a whole black frame before the handover. While such a deferred switch is pending, the block raises `busy` and refuses any further command.

The polarity of each sync input is set by its own configuration pin. A sync event is the cycle in which the input first reaches its active level.

Top module: `lcdsw_top`

## Requirements
- R1: After reset, cmd_mode=1 and disp_en, black_force, timing_run and busy are all 0.
- R2: Accepted code 0x00 enters streaming on the next cycle: disp_en=1, timing_run=1, cmd_mode=0, busy=0.
- R3: Accepted codes 0x02 and 0x14 enter plain command mode on the next cycle: cmd_mode=1, disp_en=0, timing_run=0, busy=0.
- R4: Accepted code 0x15 enters command mode on the next cycle with the timing kept running and data off: cmd_mode=1, timing_run=1, disp_en=0.
- R5: Accepted code 0x11 keeps disp_en=1 with busy=1 until a vertical sync event; the cycle after that event shows cmd_mode=1 and busy=0. Horizontal events have no effect while it waits.
- R6: Accepted code 0x12 keeps disp_en=1 with busy=1 until a horizontal sync event; the cycle after that event shows cmd_mode=1 and busy=0. Vertical events have no effect while it waits.
- R7: Accepted code 0x13 keeps displaying until a vertical sync event. It then holds black_force=1 with busy=1 for one frame, until the next vertical sync event. The cycle after that second event shows cmd_mode=1 with black_force=0.
- R8: Each sync input has a polarity pin: 1 means active-high, 0 means active-low. An event is a clock edge at which the input is active after being inactive at the previous edge. Holding the active level produces no further event.
- R9: While busy=1, every command strobe is ignored and the pending switch proceeds unchanged.
- R10: A strobe with a code other than 0x00, 0x02, 0x11, 0x12, 0x13, 0x14 or 0x15 leaves all outputs unchanged.
- R11: busy=1 exactly while a sync-bounded switch is pending. It is 0 in streaming and in both command modes, and it is never 1 together with cmd_mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| hsync_act_high | input | 1 | 1 = horizontal sync active-high, 0 = active-low |
| vsync_act_high | input | 1 | 1 = vertical sync active-high, 0 = active-low |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code |
| disp_en | output | 1 | Pixel data enable |
| black_force | output | 1 | Force output pixels to black |
| cmd_mode | output | 1 | Panel interface is in command mode |
| timing_run | output | 1 | Display timing keeps running |
| busy | output | 1 | Deferred switch pending |

## Verification
The assertions check the following on every cycle:
- command mode and pixel enable are never both high;
- busy never coincides with command mode;
- the black frame only appears while busy;
- a pending wait does not end without a sync event;
- an unknown code leaves the outputs still;
- a qualifying sync event in a wait state reaches command mode one cycle later;
- a held sync level never yields two events in a row.

Only the bench scenarios can show the rest:
- that the wrong sync kind is ignored while waiting;
- the exact two-event sequence of the black-frame variant;
- that commands during a pending switch are dropped;
- that an active-low polarity setting moves the event to the falling level.

// File: rtl/lcdsw_pkg.sv
package lcdsw_pkg;

    localparam int CODE_W   = 8;
    localparam int NUM_SYNC = 2;
    localparam int SYNC_H   = 0;
    localparam int SYNC_V   = 1;

    localparam logic [CODE_W-1:0] CODE_STREAM   = 8'h00;
    localparam logic [CODE_W-1:0] CODE_CMD_OFF  = 8'h02;
    localparam logic [CODE_W-1:0] CODE_AT_VSYNC = 8'h11;
    localparam logic [CODE_W-1:0] CODE_AT_HSYNC = 8'h12;
    localparam logic [CODE_W-1:0] CODE_BLACK_V  = 8'h13;
    localparam logic [CODE_W-1:0] CODE_CMD_ANY  = 8'h14;
    localparam logic [CODE_W-1:0] CODE_CMD_RUN  = 8'h15;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_STREAM,
        ST_WAIT_V,
        ST_WAIT_H,
        ST_WAIT_V1,
        ST_BLACK,
        ST_CMD_RUN
    } sw_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_STREAM,
        ACT_CMD_NOW,
        ACT_CMD_RUN,
        ACT_AT_V,
        ACT_AT_H,
        ACT_BLACK
    } sw_act_e;

    typedef struct packed {
        sw_state_e st;
        logic      cmd_mode;
        logic      timing_run;
        logic      disp_en;
        logic      black;
        logic      busy;
    } sw_regs_t;

endpackage

// File: rtl/lcdsw_sync_det.sv
module lcdsw_sync_det (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic act_high,
    output logic evt
);
    logic lvl_d, lvl_q;
    logic active;

    always_comb begin
        active = act_high ? raw_in : ~raw_in;
        lvl_d  = active;
        evt    = active & ~lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    // R8: a held active level gives one event only
    a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && $stable(act_high) && $stable(raw_in)) |=> !evt);

endmodule

// File: rtl/lcdsw_cmd_dec.sv
module lcdsw_cmd_dec
    import lcdsw_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output sw_act_e           act
);
    always_comb begin
        unique case (code)
            CODE_STREAM:   act = ACT_STREAM;
            CODE_CMD_OFF:  act = ACT_CMD_NOW;
            CODE_CMD_ANY:  act = ACT_CMD_NOW;
            CODE_CMD_RUN:  act = ACT_CMD_RUN;
            CODE_AT_VSYNC: act = ACT_AT_V;
            CODE_AT_HSYNC: act = ACT_AT_H;
            CODE_BLACK_V:  act = ACT_BLACK;
            default:       act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/lcdsw_top.sv
module lcdsw_top
    import lcdsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              hsync_act_high,
    input  logic              vsync_act_high,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output logic              disp_en,
    output logic              black_force,
    output logic              cmd_mode,
    output logic              timing_run,
    output logic              busy
);
    logic [NUM_SYNC-1:0] sync_raw, sync_pol, evt;
    sw_act_e             act;
    sw_regs_t            r_d, r_q;

    assign sync_raw[SYNC_H] = hsync_in;
    assign sync_raw[SYNC_V] = vsync_in;
    assign sync_pol[SYNC_H] = hsync_act_high;
    assign sync_pol[SYNC_V] = vsync_act_high;

    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
        lcdsw_sync_det u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (sync_raw[g]),
            .act_high (sync_pol[g]),
            .evt      (evt[g])
        );
    end

    lcdsw_cmd_dec u_dec (
        .code (cmd_code),
        .act  (act)
    );

    always_comb begin
        sw_state_e nst;
        nst = r_q.st;
        unique case (r_q.st)
            ST_CMD, ST_STREAM, ST_CMD_RUN: begin
                if (cmd_valid) begin
                    unique case (act)
                        ACT_STREAM:  nst = ST_STREAM;
                        ACT_CMD_NOW: nst = ST_CMD;
                        ACT_CMD_RUN: nst = ST_CMD_RUN;
                        ACT_AT_V:    nst = ST_WAIT_V;
                        ACT_AT_H:    nst = ST_WAIT_H;
                        ACT_BLACK:   nst = ST_WAIT_V1;
                        default:     nst = r_q.st;
                    endcase
                end
            end
            ST_WAIT_V:  if (evt[SYNC_V]) nst = ST_CMD;
            ST_WAIT_H:  if (evt[SYNC_H]) nst = ST_CMD;
            ST_WAIT_V1: if (evt[SYNC_V]) nst = ST_BLACK;
            ST_BLACK:   if (evt[SYNC_V]) nst = ST_CMD;
            default:    nst = ST_CMD;
        endcase

        r_d.st         = nst;
        r_d.cmd_mode   = (nst == ST_CMD) || (nst == ST_CMD_RUN);
        r_d.timing_run = (nst != ST_CMD);
        r_d.disp_en    = (nst == ST_STREAM) || (nst == ST_WAIT_V) || (nst == ST_WAIT_H)
                       || (nst == ST_WAIT_V1) || (nst == ST_BLACK);
        r_d.black      = (nst == ST_BLACK);
        r_d.busy       = (nst == ST_WAIT_V) || (nst == ST_WAIT_H)
                       || (nst == ST_WAIT_V1) || (nst == ST_BLACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st         <= ST_CMD;
            r_q.cmd_mode   <= 1'b1;
            r_q.timing_run <= 1'b0;
            r_q.disp_en    <= 1'b0;
            r_q.black      <= 1'b0;
            r_q.busy       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign disp_en     = r_q.disp_en;
    assign black_force = r_q.black;
    assign cmd_mode    = r_q.cmd_mode;
    assign timing_run  = r_q.timing_run;
    assign busy        = r_q.busy;

    // R11: busy never in command mode
    a_r11_busy_not_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_mode);
    // R3: command mode carries no pixel data
    a_r3_cmd_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mode |-> !disp_en);
    // R7: black frame only during a pending switch with timing on
    a_r7_black_busy: assert property (@(posedge clk) disable iff (!rst_n)
        black_force |-> (busy && timing_run));
    // R5: vertical event ends a vsync wait
    a_r5_v_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_V && evt[SYNC_V]) |=> (cmd_mode && !busy));
    // R6: horizontal event ends an hsync wait
    a_r6_h_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_H && evt[SYNC_H]) |=> (cmd_mode && !busy));
    // R9: a pending switch ends only through a sync event
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !evt[SYNC_H] && !evt[SYNC_V]) |=> busy);
    // R10: unknown code changes nothing
    a_r10_unknown_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && act == ACT_NONE && !busy) |=>
        ($stable(cmd_mode) && $stable(disp_en) && $stable(timing_run) && $stable(busy)));

endmodule

// File: tb/tb_lcdsw_top.sv
module tb_lcdsw_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs = 1'b0, vs = 1'b0, hpol = 1'b1, vpol = 1'b1;
    logic       cv = 1'b0;
    logic [7:0] code = 8'h00;
    logic       disp_en, black_force, cmd_mode, timing_run, busy;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // expected bits: {cmd_mode, timing_run, disp_en, black_force, busy}
    localparam logic [4:0] E_CMD  = 5'b10000;
    localparam logic [4:0] E_STR  = 5'b01100;
    localparam logic [4:0] E_WAIT = 5'b01101;
    localparam logic [4:0] E_BLK  = 5'b01111;
    localparam logic [4:0] E_RUN  = 5'b11000;

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    lcdsw_top dut (
        .clk(clk), .rst_n(rst_n),
        .hsync_in(hs), .vsync_in(vs),
        .hsync_act_high(hpol), .vsync_act_high(vpol),
        .cmd_valid(cv), .cmd_code(code),
        .disp_en(disp_en), .black_force(black_force),
        .cmd_mode(cmd_mode), .timing_run(timing_run), .busy(busy)
    );

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            logic [4:0] act;
            it  = sb.pop_front();
            act = {cmd_mode, timing_run, disp_en, black_force, busy};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    task automatic cyc(input logic h, input logic v, input logic valid,
                       input logic [7:0] c, input logic [4:0] exp, input string tag);
        @(negedge clk);
        hs = h; vs = v; cv = valid; code = c;
        sb.push_back('{exp, tag});
    endtask

    task automatic cmd(input logic [7:0] c, input logic [4:0] exp, input string tag);
        cyc(hs, vs, 1'b1, c, exp, tag);
    endtask

    task automatic idle(input logic [4:0] exp, input string tag);
        cyc(hs, vs, 1'b0, 8'h00, exp, tag);
    endtask

    initial begin
        #50000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        sb.push_back('{E_CMD, "R1 reset"});
        @(negedge clk);
        rst_n = 1'b1;
        idle(E_CMD, "R1 after release");

        cmd(8'h00, E_STR, "R2 stream");
        idle(E_STR, "R2 stay");

        // R5: wait for vsync; hsync ignored
        cmd(8'h11, E_WAIT, "R5 wait");
        cyc(1, 0, 0, 8'h00, E_WAIT, "R5 hsync ignored");
        cyc(0, 0, 0, 8'h00, E_WAIT, "R5 still wait");
        cyc(0, 1, 0, 8'h00, E_CMD, "R5 vsync switch");
        cyc(0, 0, 0, 8'h00, E_CMD, "R5 hold");

        // R6: wait for hsync; vsync ignored
        cmd(8'h00, E_STR, "R2 restream");
        cmd(8'h12, E_WAIT, "R6 wait");
        cyc(0, 1, 0, 8'h00, E_WAIT, "R6 vsync ignored");
        cyc(0, 0, 0, 8'h00, E_WAIT, "R6 still wait");
        cyc(1, 0, 0, 8'h00, E_CMD, "R6 hsync switch");
        cyc(0, 0, 0, 8'h00, E_CMD, "R6 hold");

        // R7 with R9 and R8
        cmd(8'h00, E_STR, "R2 restream");
        cmd(8'h13, E_WAIT, "R7 wait first vsync");
        cmd(8'h02, E_WAIT, "R9 cmd ignored while busy");
        cmd(8'h00, E_WAIT, "R9 stream ignored while busy");
        cyc(0, 1, 0, 8'h00, E_BLK, "R7 black frame");
        cyc(0, 1, 0, 8'h00, E_BLK, "R8 held level no event");
        cyc(0, 0, 0, 8'h00, E_BLK, "R7 black continues");
        cyc(1, 0, 0, 8'h00, E_BLK, "R7 hsync ignored in black");
        cyc(0, 1, 0, 8'h00, E_CMD, "R7 second vsync switch");
        cyc(0, 0, 0, 8'h00, E_CMD, "R7 hold");

        cmd(8'h15, E_RUN, "R4 cmd timing run");
        idle(E_RUN, "R4 stay");
        cmd(8'h00, E_STR, "R2 from run");
        cmd(8'h14, E_CMD, "R3 code 14");
        cmd(8'h00, E_STR, "R2 restream");
        cmd(8'h02, E_CMD, "R3 code 02");
        cmd(8'h7E, E_CMD, "R10 unknown in cmd");
        cmd(8'h00, E_STR, "R2 restream");
        cmd(8'h01, E_STR, "R10 unknown in stream");
        cmd(8'h13 ^ 8'h80, E_STR, "R10 unknown 93");
        idle(E_STR, "R11 not busy streaming");

        // R8 active-low hsync: high level is now inactive
        @(negedge clk);
        hpol = 1'b0; hs = 1'b1; cv = 1'b0;
        sb.push_back('{E_STR, "R8 polarity change"});
        cmd(8'h12, E_WAIT, "R8 wait low-active hsync");
        cyc(1, 0, 0, 8'h00, E_WAIT, "R8 high is inactive");
        cyc(0, 0, 0, 8'h00, E_CMD, "R8 low level switches");

        idle(E_CMD, "R11 final");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule